// File: doc/BRIEF.md
# Multi-Format Serial Audio Shifter

This block moves PCM samples between a parallel word stream and a serial audio link made of a bit clock, a frame sync and one data line in each direction. Both clocks come from outside. The block oversamples the bit clock and frame sync with its own system clock and finds their edges. Four framings are supported: I2S, left-justified, DSP with a one-bit delay (DSP-A) and DSP with no delay (DSP-B). The word length is 16 or 32 bits and the channel count runs from 1 to 16.

Transmit words arrive on a valid/ready stream and go into a one-word holding register. They leave most significant bit first. Received words leave as single-cycle valid pulses, each tagged with the channel slot it came from. A two-channel I2S or left-justified frame is split into two phases of one word each, and the second phase starts at the opposite frame-sync edge. Every other configuration packs all channel words back to back into a single phase.

Top module: `sas_shifter`

## Requirements
- R1: Frame sync is sampled at each bit-clock falling edge. In I2S format (cfg_fmt=0) a frame starts at a high-to-low frame-sync change. In left-justified (1), DSP-A (2) and DSP-B (3) formats a frame starts at a low-to-high change. Counting the falling edge that sees the start as edge 0, the first word's MSB is launched at edge 1 for I2S and DSP-A, and at edge 0 for left-justified and DSP-B.
- R2: cfg_wlen32=0 selects 16-bit words and cfg_wlen32=1 selects 32-bit words. The same length applies to every word. Transmit words go out MSB first, taken from bits [wlen-1:0] of tx_data. The upper bits are ignored.
- R3: With two channels (cfg_chan_m1=1) in I2S or left-justified format, the frame has two phases of one word each. The second word starts at the opposite frame-sync change, with the same data delay as the first word, and it carries channel index 1.
- R4: In every other case the frame is one phase holding cfg_chan_m1+1 words back to back. A frame-sync change in the non-start direction is ignored. Received words carry channel index 0 to cfg_chan_m1, in order.
- R5: sd_o changes only after a bit-clock falling edge. sd_i is captured at the bit-clock rising edge.
- R6: sd_o is 0 at every bit slot that is not a data bit of a word. This covers the time before the first frame, the delay slot and the trailing slots.
- R7: If no word is held when a transmit word must start, that word is sent as all zeros and tx_underflow is set. tx_underflow stays set until reset.
- R8: Each received word appears on rx_data with rx_valid high for exactly one system-clock cycle, and rx_chan holds its channel index at the same time. 16-bit words are right-aligned and zero-extended.
- R9: During synchronous reset, sd_o, rx_valid and tx_underflow are 0 and tx_ready is 1.
- R10: The transmit side holds one word. tx_ready is low from the cycle after a handshake until that word starts to shift out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 2 | Framing: 0 I2S, 1 left-justified, 2 DSP-A, 3 DSP-B |
| cfg_wlen32 | input | 1 | Word length: 0 for 16 bits, 1 for 32 bits |
| cfg_chan_m1 | input | CHW | Channel count minus one |
| bclk_i | input | 1 | Bit clock, synchronous to clk |
| fs_i | input | 1 | Frame sync, changes at bit-clock falling edges |
| sd_i | input | 1 | Serial receive data |
| sd_o | output | 1 | Serial transmit data |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | SW_LONG | Transmit word |
| tx_ready | output | 1 | Holding register is empty |
| rx_valid | output | 1 | Received word pulse |
| rx_data | output | SW_LONG | Received word |
| rx_chan | output | CHW | Channel index of the received word |
| tx_underflow | output | 1 | Sticky transmit underflow flag |

## Verification
The assertions assume the following about the inputs. The bit clock runs well below the system clock, with each half period lasting at least four system-clock cycles. The configuration changes only while reset is high. Frame sync changes only together with a bit-clock falling edge. The stimulus respects all of this: it holds each bit-clock level for six cycles, changes frame sync and sd_i in the same cycle as the falling edge, and applies each new configuration under reset. Frames are sized so that every word fits, with trailing slots left over.

// File: rtl/sas_pkg.sv
package sas_pkg;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_DSPA = 2'd2,
    FMT_DSPB = 2'd3
  } sas_fmt_e;

  // one-bit data delay after the frame start edge
  function automatic logic fmt_delayed(sas_fmt_e f);
    return (f == FMT_I2S) || (f == FMT_DSPA);
  endfunction

  // formats whose stereo frames split into two phases
  function automatic logic fmt_paired(sas_fmt_e f);
    return (f == FMT_I2S) || (f == FMT_LJ);
  endfunction

  // frame begins on a falling frame-sync change
  function automatic logic fmt_start_low(sas_fmt_e f);
    return f == FMT_I2S;
  endfunction

endpackage

// File: rtl/sas_insync.sv
module sas_insync #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_i,
  input  logic fs_i,
  input  logic sd_i,
  output logic fs_s,
  output logic sd_s,
  output logic fall_ev,
  output logic rise_ev
);

  logic [STAGES-1:0][2:0] pipe;
  logic [2:0]             last;
  logic                   bclk_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {bclk_i, fs_i, sd_i};
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], {bclk_i, fs_i, sd_i}};
      end
    end
  endgenerate

  assign last = pipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) bclk_d <= 1'b0;
    else     bclk_d <= last[2];
  end

  assign fs_s    = last[1];
  assign sd_s    = last[0];
  assign fall_ev = bclk_d & ~last[2];
  assign rise_ev = ~bclk_d & last[2];

endmodule

// File: rtl/sas_framer.sv
module sas_framer
  import sas_pkg::*;
#(
  parameter int SW_LONG  = 32,
  parameter int SW_SHORT = 16,
  parameter int NCH_MAX  = 16,
  parameter int CHW      = $clog2(NCH_MAX)
) (
  input  logic           clk,
  input  logic           rst,
  input  sas_fmt_e       fmt,
  input  logic           wlen32,
  input  logic [CHW-1:0] chan_m1,
  input  logic           fs_s,
  input  logic           fall_ev,
  output logic           slot_ev,
  output logic           slot_valid,
  output logic           slot_first,
  output logic           slot_last,
  output logic [CHW-1:0] slot_chan
);

  localparam int BPW   = $clog2(SW_LONG * NCH_MAX + 2) + 1;
  localparam int LOG_L = $clog2(SW_LONG);
  localparam int LOG_S = $clog2(SW_SHORT);

  logic [BPW-1:0] pos_q, pos_n, words, pbits, dpos, biw, wmask, widx;
  logic           phase_q, phase_n, live_q, live_n, fs_last_q;
  logic           dual, lead, trail, dly, in_data;

  always_comb begin
    dual  = (chan_m1 == CHW'(1)) && fmt_paired(fmt);
    lead  = fmt_start_low(fmt) ? (fs_last_q & ~fs_s) : (~fs_last_q & fs_s);
    trail = fmt_start_low(fmt) ? (~fs_last_q & fs_s) : (fs_last_q & ~fs_s);
    pos_n   = pos_q;
    phase_n = phase_q;
    live_n  = live_q;
    if (lead) begin
      pos_n   = '0;
      phase_n = 1'b0;
      live_n  = 1'b1;
    end else if (dual && trail && live_q) begin
      pos_n   = '0;
      phase_n = 1'b1;
    end else if (pos_q != '1) begin
      pos_n = pos_q + BPW'(1);
    end
    dly     = fmt_delayed(fmt);
    words   = dual ? BPW'(1) : (BPW'(chan_m1) + BPW'(1));
    pbits   = wlen32 ? (words << LOG_L) : (words << LOG_S);
    wmask   = wlen32 ? BPW'(SW_LONG - 1) : BPW'(SW_SHORT - 1);
    dpos    = pos_n - BPW'(dly);
    in_data = live_n && (pos_n >= BPW'(dly)) && (dpos < pbits);
    biw     = dpos & wmask;
    widx    = wlen32 ? (dpos >> LOG_L) : (dpos >> LOG_S);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q      <= '1;
      phase_q    <= 1'b0;
      live_q     <= 1'b0;
      fs_last_q  <= 1'b0;
      slot_ev    <= 1'b0;
      slot_valid <= 1'b0;
      slot_first <= 1'b0;
      slot_last  <= 1'b0;
      slot_chan  <= '0;
    end else begin
      slot_ev <= fall_ev;
      if (fall_ev) begin
        pos_q      <= pos_n;
        phase_q    <= phase_n;
        live_q     <= live_n;
        fs_last_q  <= fs_s;
        slot_valid <= in_data;
        slot_first <= in_data && (biw == '0);
        slot_last  <= in_data && (biw == wmask);
        slot_chan  <= dual ? CHW'(phase_n) : widx[CHW-1:0];
      end
    end
  end

endmodule

// File: rtl/sas_tx.sv
module sas_tx #(
  parameter int SW_LONG  = 32,
  parameter int SW_SHORT = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wlen32,
  input  logic               slot_ev,
  input  logic               slot_valid,
  input  logic               slot_first,
  input  logic               tx_valid,
  input  logic [SW_LONG-1:0] tx_data,
  output logic               tx_ready,
  output logic               sd_o,
  output logic               tx_underflow
);

  localparam int PADW = SW_LONG - SW_SHORT;

  logic [SW_LONG-1:0] hold_q, sh_q, aligned;
  logic               full_q;

  assign aligned  = wlen32 ? hold_q : {hold_q[SW_SHORT-1:0], {PADW{1'b0}}};
  assign tx_ready = ~full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q       <= '0;
      sh_q         <= '0;
      full_q       <= 1'b0;
      sd_o         <= 1'b0;
      tx_underflow <= 1'b0;
    end else begin
      if (tx_valid && !full_q) begin
        hold_q <= tx_data;
        full_q <= 1'b1;
      end
      if (slot_ev) begin
        if (!slot_valid) begin
          sd_o <= 1'b0;
        end else if (slot_first) begin
          if (full_q) begin
            sd_o   <= aligned[SW_LONG-1];
            sh_q   <= aligned << 1;
            full_q <= 1'b0;
          end else begin
            sd_o         <= 1'b0;
            sh_q         <= '0;
            tx_underflow <= 1'b1;
          end
        end else begin
          sd_o <= sh_q[SW_LONG-1];
          sh_q <= sh_q << 1;
        end
      end
    end
  end

endmodule

// File: rtl/sas_rx.sv
module sas_rx #(
  parameter int SW_LONG  = 32,
  parameter int SW_SHORT = 16,
  parameter int CHW      = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wlen32,
  input  logic               rise_ev,
  input  logic               sd_s,
  input  logic               slot_valid,
  input  logic               slot_last,
  input  logic [CHW-1:0]     slot_chan,
  output logic               rx_valid,
  output logic [SW_LONG-1:0] rx_data,
  output logic [CHW-1:0]     rx_chan
);

  localparam int PADW = SW_LONG - SW_SHORT;

  logic [SW_LONG-1:0] sh_q, sh_nx;

  assign sh_nx = {sh_q[SW_LONG-2:0], sd_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_chan  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (rise_ev && slot_valid) begin
        sh_q <= sh_nx;
        if (slot_last) begin
          rx_valid <= 1'b1;
          rx_data  <= wlen32 ? sh_nx : {{PADW{1'b0}}, sh_nx[SW_SHORT-1:0]};
          rx_chan  <= slot_chan;
        end
      end
    end
  end

endmodule

// File: rtl/sas_shifter.sv
module sas_shifter
  import sas_pkg::*;
#(
  parameter int SW_LONG   = 32,
  parameter int SW_SHORT  = 16,
  parameter int NCH_MAX   = 16,
  parameter int IN_STAGES = 1,
  localparam int CHW      = $clog2(NCH_MAX)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cfg_fmt,
  input  logic               cfg_wlen32,
  input  logic [CHW-1:0]     cfg_chan_m1,
  input  logic               bclk_i,
  input  logic               fs_i,
  input  logic               sd_i,
  output logic               sd_o,
  input  logic               tx_valid,
  input  logic [SW_LONG-1:0] tx_data,
  output logic               tx_ready,
  output logic               rx_valid,
  output logic [SW_LONG-1:0] rx_data,
  output logic [CHW-1:0]     rx_chan,
  output logic               tx_underflow
);

  sas_fmt_e       fmt;
  logic           fs_s, sd_s, fall_ev, rise_ev;
  logic           slot_ev, slot_valid, slot_first, slot_last;
  logic [CHW-1:0] slot_chan;

  assign fmt = sas_fmt_e'(cfg_fmt);

  sas_insync #(.STAGES(IN_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bclk_i(bclk_i), .fs_i(fs_i), .sd_i(sd_i),
    .fs_s(fs_s), .sd_s(sd_s), .fall_ev(fall_ev), .rise_ev(rise_ev)
  );

  sas_framer #(
    .SW_LONG(SW_LONG), .SW_SHORT(SW_SHORT), .NCH_MAX(NCH_MAX), .CHW(CHW)
  ) u_framer (
    .clk(clk), .rst(rst), .fmt(fmt), .wlen32(cfg_wlen32), .chan_m1(cfg_chan_m1),
    .fs_s(fs_s), .fall_ev(fall_ev), .slot_ev(slot_ev), .slot_valid(slot_valid),
    .slot_first(slot_first), .slot_last(slot_last), .slot_chan(slot_chan)
  );

  sas_tx #(.SW_LONG(SW_LONG), .SW_SHORT(SW_SHORT)) u_tx (
    .clk(clk), .rst(rst), .wlen32(cfg_wlen32), .slot_ev(slot_ev),
    .slot_valid(slot_valid), .slot_first(slot_first), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .sd_o(sd_o),
    .tx_underflow(tx_underflow)
  );

  sas_rx #(.SW_LONG(SW_LONG), .SW_SHORT(SW_SHORT), .CHW(CHW)) u_rx (
    .clk(clk), .rst(rst), .wlen32(cfg_wlen32), .rise_ev(rise_ev), .sd_s(sd_s),
    .slot_valid(slot_valid), .slot_last(slot_last), .slot_chan(slot_chan),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_chan(rx_chan)
  );

endmodule

// File: rtl/sas_shifter_chk.sv
module sas_shifter_chk #(
  parameter int SW_LONG  = 32,
  parameter int SW_SHORT = 16,
  parameter int CHW      = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_wlen32,
  input logic [CHW-1:0]     cfg_chan_m1,
  input logic               bclk_i,
  input logic               sd_o,
  input logic               tx_valid,
  input logic               tx_ready,
  input logic               rx_valid,
  input logic [SW_LONG-1:0] rx_data,
  input logic [CHW-1:0]     rx_chan,
  input logic               tx_underflow
);

  logic       bclk_seen;
  logic [2:0] since_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_seen  <= 1'b0;
      since_fall <= '1;
    end else begin
      bclk_seen <= bclk_i;
      if (bclk_seen && !bclk_i)  since_fall <= '0;
      else if (since_fall != '1) since_fall <= since_fall + 3'd1;
    end
  end

  p_launch_fall_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd_o) |-> since_fall <= 3'd3);

  p_udf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    tx_underflow |=> tx_underflow);

  p_rx_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  p_rx_zext_r2: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !cfg_wlen32 |-> rx_data[SW_LONG-1:SW_SHORT] == '0);

  p_rx_chan_r4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> rx_chan <= cfg_chan_m1);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_ready |=> !tx_ready);

endmodule

bind sas_shifter sas_shifter_chk #(
  .SW_LONG(SW_LONG), .SW_SHORT(SW_SHORT), .CHW(CHW)
) u_chk (
  .clk(clk), .rst(rst), .cfg_wlen32(cfg_wlen32), .cfg_chan_m1(cfg_chan_m1),
  .bclk_i(bclk_i), .sd_o(sd_o), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_data(rx_data), .rx_chan(rx_chan),
  .tx_underflow(tx_underflow)
);

// File: tb/test_sas_shifter.sv
`timescale 1ns/1ps
module test_sas_shifter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_fmt = 2'd0;
  logic        cfg_wlen32 = 1'b0;
  logic [3:0]  cfg_chan_m1 = 4'd0;
  logic        bclk = 1'b0, fs = 1'b0, sd_i = 1'b0;
  logic        sd_o, tx_ready, rx_valid, tx_underflow;
  logic        tx_valid = 1'b0;
  logic [31:0] tx_data = '0;
  logic [31:0] rx_data;
  logic [3:0]  rx_chan;

  int nvec = 0, nfail = 0;
  bit done = 0;
  logic [31:0] txq [64];
  logic [31:0] rxq [64];
  logic [31:0] rxg [64];
  int          rxc [64];
  int feed_idx = 0, feed_lim = 0, rx_cnt = 0;

  always #2 clk = ~clk;

  sas_shifter i_sas_shifter (
    .clk(clk), .rst(rst), .cfg_fmt(cfg_fmt), .cfg_wlen32(cfg_wlen32),
    .cfg_chan_m1(cfg_chan_m1), .bclk_i(bclk), .fs_i(fs), .sd_i(sd_i),
    .sd_o(sd_o), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_chan(rx_chan),
    .tx_underflow(tx_underflow)
  );

  // transmit feeder
  always @(negedge clk) begin
    tx_valid <= (feed_idx < feed_lim);
    tx_data  <= (feed_idx < 64) ? txq[feed_idx] : 32'h0;
  end
  always @(posedge clk) if (!rst && tx_valid && tx_ready) feed_idx++;

  // receive monitor
  always @(negedge clk) begin
    if (!rst && rx_valid && rx_cnt < 64) begin
      rxg[rx_cnt] = rx_data;
      rxc[rx_cnt] = int'(rx_chan);
      rx_cnt++;
    end
  end

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_slot(logic fsv, logic rbit, logic exp_tx, string tag);
    @(negedge clk);
    bclk = 1'b0; fs = fsv; sd_i = rbit;
    repeat (6) @(negedge clk);
    chk({31'b0, sd_o}, {31'b0, exp_tx}, tag);
    bclk = 1'b1;
    repeat (3) @(negedge clk);
    sd_i = ~rbit;  // changes after the rising-edge capture point (R5)
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] txval(int fr, int ch, int f);
    return (32'h9E37_79B9 * (fr * 17 + ch * 5 + f + 1)) ^ 32'h5A00_C3A5;
  endfunction
  function automatic logic [31:0] rxval(int fr, int ch, int f);
    return (32'h85EB_CA6B * (fr * 13 + ch * 7 + f + 3)) ^ 32'h0F1E_2D3C;
  endfunction

  task automatic run_cfg(int f, int w, int n, int frames, bit starve);
    int wl = w ? 32 : 16;
    bit dual = (n == 2) && (f < 2);
    int dly = (f == 0 || f == 2) ? 1 : 0;
    int half = wl + 2;
    int fl = dual ? 2 * half : n * wl + 4;
    int fsh = fl / 2;
    bit idle_fs = (f == 0);
    int lim = dual ? wl : n * wl;
    rst = 1'b1;
    cfg_fmt = 2'(f); cfg_wlen32 = w[0]; cfg_chan_m1 = 4'(n - 1);
    bclk = 1'b0; fs = idle_fs; sd_i = 1'b0;
    for (int fr = 0; fr < frames; fr++)
      for (int ch = 0; ch < n; ch++) begin
        txq[fr * n + ch] = txval(fr, ch, f);
        rxq[fr * n + ch] = rxval(fr, ch, f + w);
      end
    feed_idx = 0; feed_lim = starve ? n : frames * n; rx_cnt = 0;
    repeat (3) @(negedge clk);
    chk({31'b0, sd_o}, 32'h0, "R9 reset sd_o");
    chk({31'b0, rx_valid}, 32'h0, "R9 reset rx_valid");
    chk({31'b0, tx_underflow}, 32'h0, "R9 reset underflow");
    chk({31'b0, tx_ready}, 32'h1, "R9 reset tx_ready");
    rst = 1'b0;
    for (int i = 0; i < 3; i++) do_slot(idle_fs, 1'b1, 1'b0, "R6 idle zero");
    chk({31'b0, tx_ready}, 32'h0, "R10 ready low while holding");
    for (int fr = 0; fr < frames; fr++) begin
      for (int k = 0; k < fl; k++) begin
        int ph = (dual && k >= half) ? 1 : 0;
        int kk = k - ph * half;
        int db = kk - dly;
        bit v = (db >= 0) && (db < lim);
        logic fsv, tb, rb;
        string tag;
        fsv = (f == 0) ? (k >= fsh) : (f == 1) ? (k < fsh) : (k == 0);
        tb = 1'b0; rb = k[0];
        tag = "R6 trailing zero";
        if (v) begin
          int wi = dual ? ph : db / wl;
          int b = db % wl;
          rb = rxq[fr * n + wi][wl - 1 - b];
          if (starve && fr > 0) begin
            tag = "R7 underflow zero";
          end else begin
            tb = txq[fr * n + wi][wl - 1 - b];
            if (kk == dly)  tag = "R1 data delay";
            else if (ph == 1) tag = "R3 second phase";
            else              tag = "R2 MSB-first shift";
          end
        end
        do_slot(fsv, rb, tb, tag);
      end
    end
    repeat (4) @(negedge clk);
    chk(32'(rx_cnt), 32'(frames * n), "R8 received word count");
    for (int i = 0; i < frames * n && i < rx_cnt; i++) begin
      chk(rxg[i], w ? rxq[i] : {16'h0, rxq[i][15:0]}, "R5 R8 received word");
      chk(32'(rxc[i]), 32'(i % n), "R4 channel index");
    end
    chk({31'b0, tx_underflow}, {31'b0, starve}, "R7 sticky underflow");
    if (!starve) chk({31'b0, tx_ready}, 32'h1, "R10 ready after drain");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    for (int f = 0; f < 4; f++)
      for (int w = 0; w < 2; w++)
        for (int n = 1; n <= 4; n++)
          run_cfg(f, w, n, 2, 1'b0);
    run_cfg(2, 1, 16, 2, 1'b0);
    run_cfg(3, 0, 16, 2, 1'b0);
    run_cfg(0, 0, 2, 2, 1'b1);
    run_cfg(3, 1, 3, 2, 1'b1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule